// File: doc/BRIEF.md
# Sixteen-Bit Event Timer with Reload and Divider Output

The block is a 16-bit up-counter that a processor reaches through an 8-bit register window. It advances either on a qualified clock tick supplied by the surrounding chip or on a chosen edge of an asynchronous event pin. When the count wraps past its maximum it takes its next value from a reload register, raises a sticky interrupt request and flips a square-wave divider output. Software then sees the divider output run at half the wrap rate.

Because the bus is one byte wide and the counter is two bytes wide, both directions go through a low-byte staging register. A read of the high byte captures the low byte at the same instant, so the pair always belongs to one count value. A write of the low byte is only staged, and the high-byte write commits the full 16-bit word in one cycle. Software therefore never sees or creates a torn value. While counting is halted, that commit also loads the running count, so the first interval after a start is exact.

Top module: `pfd_event_timer`

## Requirements
- R1: With the run bit (control bit 0) at 1 and the source bit (control bit 2) at 0, the count rises by one at every clock edge where `tickIn` is 1. With the source bit at 1, `tickIn` has no effect.
- R2: A count step taken at 0xFFFF loads the reload value into the count and sets `irqFlag`. The flag holds until a control write with bit 3 at 0 clears it. A control write with bit 3 at 1 does not set it. A wrap and a clearing write in the same cycle leave the flag at 1.
- R3: With the source bit at 1, `eventIn` passes through a two-stage synchronizer, and exactly one count is taken per selected edge. The edge bit (control bit 1) selects the edge: 0 counts rising edges and 1 counts falling edges.
- R4: With the run bit at 0, the count holds its value whatever `tickIn` and `eventIn` do, unless a high-byte write loads it.
- R5: A write to address 0 only stages a low byte and leaves the count unchanged. A write to address 1 places {written byte, staged byte} into the reload register in one step. The same write also loads the count when the run bit is 0, and leaves the count alone when the run bit is 1.
- R6: A read of address 1 returns count bits 15:8 and at that edge captures count bits 7:0. A later read of address 0 returns the captured byte.
- R7: Every wrap inverts `pfdOut`, and nothing else changes it.
- R8: Address 2 reads as {4'b0, flag, source, edge, run}, with bits 7:4 always 0. Address 3 reads as 0.
- R9: After reset the count, the reload register and the control bits are 0, and `irqFlag` and `pfdOut` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 2 | Register address: 0 low byte, 1 high byte, 2 control |
| busWr | input | 1 | Write strobe, one cycle per access |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for the addressed register |
| tickIn | input | 1 | Internal count qualifier, one step per high cycle |
| eventIn | input | 1 | Asynchronous external event pin |
| irqFlag | output | 1 | Sticky overflow request |
| pfdOut | output | 1 | Divider output, toggled on each wrap |

## Verification
Corruption of the count or of the reload register shows up through the high and low reads, which are taken while the count is frozen. A bad reload value appears on the first read after the wrap, one cycle later. A flag or divider register that drifts from the wrap shows on `irqFlag` or `pfdOut` in the cycle after the wrapping edge. A fault in the synchronizer or edge selection leaves a count that differs from the number of pulses of the chosen polarity, and it can be read once the pulse train ends.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam logic [1:0] ADDR_LOW  = 2'd0;
  localparam logic [1:0] ADDR_HIGH = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;

  localparam int BIT_RUN  = 0;
  localparam int BIT_EDGE = 1;
  localparam int BIT_SRC  = 2;
  localparam int BIT_FLAG = 3;

  typedef struct packed {
    logic commit;
    logic latchLow;
    logic clrFlag;
  } tcStrobe_t;
endpackage

// File: rtl/tc_datapath.sv
module tc_datapath
  import tc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  tcStrobe_t        strb,
  input  logic [CNT_W-1:0] commitVal,
  input  logic             runEn,
  input  logic             edgeSel,
  input  logic             srcSel,
  input  logic             tickIn,
  input  logic             eventIn,
  output logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] preVal,
  output logic             ovfPulse,
  output logic             pfdOut
);
  localparam int SMSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic evPrev;
  logic edgeHit;
  logic step;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= eventIn;
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], eventIn};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) evPrev <= 1'b0;
    else       evPrev <= syncQ[SMSB];

  always_comb begin
    edgeHit  = edgeSel ? (evPrev & ~syncQ[SMSB]) : (~evPrev & syncQ[SMSB]);
    step     = runEn & (srcSel ? edgeHit : tickIn);
    ovfPulse = step & (&cntVal);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal <= '0;
      preVal <= '0;
      pfdOut <= 1'b0;
    end else begin
      if (strb.commit) preVal <= commitVal;
      if (ovfPulse) begin
        cntVal <= preVal;
        pfdOut <= ~pfdOut;
      end else if (step) begin
        cntVal <= cntVal + 1'b1;
      end else if (strb.commit && !runEn) begin
        cntVal <= commitVal;
      end
    end
  end
endmodule

// File: rtl/tc_ctrl.sv
module tc_ctrl
  import tc_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          busAddr,
  input  logic                busWr,
  input  logic                busRd,
  input  logic [BYTE_W-1:0]   busWdata,
  output logic [BYTE_W-1:0]   busRdata,
  input  logic [2*BYTE_W-1:0] cntVal,
  input  logic                ovfPulse,
  output tcStrobe_t           strb,
  output logic [2*BYTE_W-1:0] commitVal,
  output logic                runEn,
  output logic                edgeSel,
  output logic                srcSel,
  output logic                irqFlag
);
  logic [BYTE_W-1:0] wrLowBuf;
  logic [BYTE_W-1:0] rdLowBuf;
  logic wrLow;
  logic wrCtrl;

  always_comb begin
    wrLow         = busWr && (busAddr == ADDR_LOW);
    wrCtrl        = busWr && (busAddr == ADDR_CTRL);
    strb.commit   = busWr && (busAddr == ADDR_HIGH);
    strb.latchLow = busRd && (busAddr == ADDR_HIGH);
    strb.clrFlag  = wrCtrl && !busWdata[BIT_FLAG];
    commitVal     = {busWdata, wrLowBuf};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrLowBuf <= '0;
      rdLowBuf <= '0;
      runEn    <= 1'b0;
      edgeSel  <= 1'b0;
      srcSel   <= 1'b0;
      irqFlag  <= 1'b0;
    end else begin
      if (wrLow)         wrLowBuf <= busWdata;
      if (strb.latchLow) rdLowBuf <= cntVal[BYTE_W-1:0];
      if (wrCtrl) begin
        runEn   <= busWdata[BIT_RUN];
        edgeSel <= busWdata[BIT_EDGE];
        srcSel  <= busWdata[BIT_SRC];
      end
      if (ovfPulse)          irqFlag <= 1'b1;
      else if (strb.clrFlag) irqFlag <= 1'b0;
    end
  end

  always_comb begin
    busRdata = '0;
    unique case (busAddr)
      ADDR_LOW:  busRdata = rdLowBuf;
      ADDR_HIGH: busRdata = cntVal[2*BYTE_W-1:BYTE_W];
      ADDR_CTRL: begin
        busRdata[BIT_RUN]  = runEn;
        busRdata[BIT_EDGE] = edgeSel;
        busRdata[BIT_SRC]  = srcSel;
        busRdata[BIT_FLAG] = irqFlag;
      end
      default:   busRdata = '0;
    endcase
  end
endmodule

// File: rtl/pfd_event_timer.sv
module pfd_event_timer
  import tc_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [BYTE_W-1:0] busWdata,
  output logic [BYTE_W-1:0] busRdata,
  input  logic              tickIn,
  input  logic              eventIn,
  output logic              irqFlag,
  output logic              pfdOut
);
  localparam int CNT_W = 2 * BYTE_W;

  tcStrobe_t        strb;
  logic [CNT_W-1:0] commitVal;
  logic [CNT_W-1:0] cntVal;
  logic [CNT_W-1:0] preVal;
  logic             ovfPulse;
  logic             runEn;
  logic             edgeSel;
  logic             srcSel;

  tc_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .cntVal(cntVal),
    .ovfPulse(ovfPulse), .strb(strb), .commitVal(commitVal), .runEn(runEn),
    .edgeSel(edgeSel), .srcSel(srcSel), .irqFlag(irqFlag)
  );

  tc_datapath #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .commitVal(commitVal), .runEn(runEn),
    .edgeSel(edgeSel), .srcSel(srcSel), .tickIn(tickIn), .eventIn(eventIn),
    .cntVal(cntVal), .preVal(preVal), .ovfPulse(ovfPulse), .pfdOut(pfdOut)
  );
endmodule

// File: rtl/pfd_event_timer_chk.sv
module pfd_event_timer_chk #(
  parameter int CNT_W = 16,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        busAddr,
  input logic              busWr,
  input logic              busRd,
  input logic [BYTE_W-1:0] busRdata,
  input logic [CNT_W-1:0]  cntVal,
  input logic [CNT_W-1:0]  preVal,
  input logic              ovfPulse,
  input logic              runEn,
  input logic              irqFlag,
  input logic              pfdOut
);
  AST_RELOAD_ON_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |=> cntVal == $past(preVal)); // R2
  AST_FLAG_ON_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |=> irqFlag); // R2
  AST_PFD_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |=> pfdOut != $past(pfdOut)); // R7
  AST_PFD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ovfPulse |=> $stable(pfdOut)); // R7
  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !(busWr && busAddr == 2'd1)) |=> $stable(cntVal)); // R4
  AST_STOPPED_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && busWr && busAddr == 2'd1) |=> cntVal == preVal); // R5
  AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == 2'd2) |-> busRdata[BYTE_W-1:4] == '0); // R8
endmodule

bind pfd_event_timer pfd_event_timer_chk #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
  .busRdata(busRdata), .cntVal(cntVal), .preVal(preVal), .ovfPulse(ovfPulse),
  .runEn(runEn), .irqFlag(irqFlag), .pfdOut(pfdOut)
);

// File: tb/test_pfd_event_timer.sv
module test_pfd_event_timer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [7:0] busWdata = 8'd0;
  logic [7:0] busRdata;
  logic       tickIn = 1'b0;
  logic       eventIn = 1'b0;
  logic       irqFlag;
  logic       pfdOut;

  int nRun = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  pfd_event_timer i_pfd_event_timer (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .tickIn(tickIn),
    .eventIn(eventIn), .irqFlag(irqFlag), .pfdOut(pfdOut)
  );

  task automatic check(input string req, input int act, input int exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic readCount(output logic [15:0] v);
    logic [7:0] hi, lo;
    rd(2'd1, hi);
    rd(2'd0, lo);
    v = {hi, lo};
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tickIn = 1'b1;
    repeat (n) @(negedge clk);
    tickIn = 1'b0;
  endtask

  task automatic evPulse();
    @(negedge clk); eventIn = 1'b1;
    repeat (4) @(negedge clk);
    eventIn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    logic [15:0] v;
    check("R9 irqFlag", irqFlag, 0);
    check("R9 pfdOut", pfdOut, 0);
    rd(2'd2, d); check("R9 ctrl", d, 8'h00);
    readCount(v); check("R9 count", v, 16'h0000);
  endtask

  task automatic t_load();
    logic [15:0] v;
    wr(2'd0, 8'h34); wr(2'd1, 8'h12);
    readCount(v); check("R5 R6 stopped load", v, 16'h1234);
    wr(2'd0, 8'h99);
    readCount(v); check("R5 low write staged only", v, 16'h1234);
  endtask

  task automatic t_tick();
    logic [15:0] v;
    wr(2'd2, 8'h01);
    ticks(5);
    readCount(v); check("R1 tick count", v, 16'h1239);
    wr(2'd2, 8'h00);
    ticks(7);
    evPulse();
    readCount(v); check("R4 stopped hold", v, 16'h1239);
  endtask

  task automatic t_overflow();
    logic [15:0] v;
    logic [7:0] d;
    wr(2'd0, 8'hFE); wr(2'd1, 8'hFF);
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h00); wr(2'd1, 8'h01);
    readCount(v); check("R5 running commit leaves count", v, 16'hFFFE);
    ticks(1);
    readCount(v); check("R1 step to max", v, 16'hFFFF);
    check("R2 no flag before wrap", irqFlag, 0);
    @(negedge clk);
    tickIn = 1'b1; busAddr = 2'd2; busWdata = 8'h01; busWr = 1'b1;
    @(negedge clk);
    tickIn = 1'b0; busWr = 1'b0;
    check("R2 wrap beats clear", irqFlag, 1);
    check("R7 first toggle", pfdOut, 1);
    readCount(v); check("R2 reload value", v, 16'h0100);
    wr(2'd2, 8'h09);
    check("R2 write 1 keeps flag", irqFlag, 1);
    wr(2'd2, 8'h01);
    check("R2 clear by write 0", irqFlag, 0);
    wr(2'd2, 8'h0B);
    rd(2'd2, d); check("R2 write 1 does not set", d, 8'h03);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
    wr(2'd2, 8'h01);
    ticks(1);
    check("R7 second toggle", pfdOut, 0);
    check("R2 second wrap flag", irqFlag, 1);
    readCount(v); check("R2 reload all ones", v, 16'hFFFF);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_edge();
    logic [15:0] v;
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    wr(2'd2, 8'h05);
    tickIn = 1'b1;
    repeat (3) evPulse();
    tickIn = 1'b0;
    readCount(v); check("R3 R1 rising edges, tick ignored", v, 16'h0003);
    wr(2'd2, 8'h07);
    @(negedge clk); eventIn = 1'b1;
    repeat (4) @(negedge clk);
    readCount(v); check("R3 rise ignored in falling mode", v, 16'h0003);
    eventIn = 1'b0;
    repeat (4) @(negedge clk);
    evPulse();
    readCount(v); check("R3 falling edges", v, 16'h0005);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_ctrl();
    logic [7:0] d;
    wr(2'd2, 8'hF6);
    rd(2'd2, d); check("R8 ctrl layout", d, 8'h06);
    rd(2'd3, d); check("R8 unused address", d, 8'h00);
    wr(2'd2, 8'h00);
  endtask

  initial begin
    #200000;
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_tick();
    t_overflow();
    t_edge();
    t_ctrl();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule